// File: doc/BRIEF.md
# Oversampled Phase-Frequency Detector with Up-Pulse Limiting

This block compares a reference clock with a feedback clock for a digital model of a PLL front end. Both inputs are slow square waves. A much faster system clock samples them through synchronizers, and the block finds their rising edges in the system-clock domain. For each comparison it raises a pump-up pulse when the reference edge comes first and a pump-down pulse when the feedback edge comes first. The pulse stays high until the other edge arrives, so its width in system-clock cycles equals the edge spacing. Once both edges of a comparison have been seen, the two outputs stay high together for a programmable overlap. This overlap keeps the pump legs switched on before a small phase error is measured, so small errors do not fall into a dead zone. The outputs then return to idle until the next edge.

The block also measures the reference period in system-clock cycles. It can limit the pump-up pulse, and only that pulse, to a quarter or an eighth of the most recently measured period. Limiting the up direction tames overshoot during locking. The down direction is left free because undershoot does no harm. A flag shows that the limit cut the current pulse short.

Top module: `edge_phase_detector`

## Requirements
- R1: The asynchronous active-low reset drives pump_up, pump_dn and cap_hit low at once, and it discards any period measurement made before it.
- R2: When the reference rising edge comes d system-clock cycles before the feedback rising edge, pump_up alone is high for exactly d cycles (when no limit applies) and pump_dn stays low during that time.
- R3: When the feedback rising edge comes d cycles before the reference rising edge, pump_dn alone is high for exactly d cycles and pump_up stays low during that time.
- R4: After the second edge of a comparison, pump_up and pump_dn are both high for max(1, ovl_len) cycles and then both go low. When the two edges are seen in the same cycle, the comparison gives only this overlap.
- R5: With cap_en=1 and a valid period measurement P (in system-clock cycles between reference rising edges), pump_up alone lasts at most L = max(1, P>>2) cycles when cap_sel=0, and at most L = max(1, P>>3) cycles when cap_sel=1.
- R6: If the feedback edge has not come after L up-only cycles, pump_up drops and cap_hit rises. The overlap still follows when the feedback edge arrives. cap_hit stays high until the next reference rising edge clears it. An edge spacing of exactly L does not set cap_hit.
- R7: The pump_dn width is never limited, whatever the values of cap_en and cap_sel.
- R8: With cap_en=0, pump_up has no width limit and behaves like pump_dn in the mirrored case, and cap_hit never rises.
- R9: No limit applies until one full reference period has been measured after reset. The first comparison after reset is therefore never cut short.
- R10: A rising edge on ref_in that is sampled at a system-clock edge shows on the outputs after the second following clock edge (three clock edges after it is first driven), and not before.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Fast system clock that samples both inputs |
| rst_n | input | 1 | Asynchronous active-low reset |
| ref_in | input | 1 | Reference clock, asynchronous to clk |
| fb_in | input | 1 | Feedback clock, asynchronous to clk |
| ovl_len | input | OVL_W | Overlap length in cycles; 0 is treated as 1 |
| cap_en | input | 1 | Enables the pump-up width limit |
| cap_sel | input | 1 | Limit divisor: 0 gives a quarter, 1 gives an eighth of the period |
| pump_up | output | 1 | Pump-up request |
| pump_dn | output | 1 | Pump-down request |
| cap_hit | output | 1 | Set when the limit cut pump_up; cleared by the next reference edge |

## Verification
The assertions assume that ovl_len and cap_en do not change while a comparison or its overlap is in progress. They also assume that no new rising edge arrives during an overlap, because the block ignores edges that come then. The overlap-length property relies on the first of these assumptions. The stimulus changes configuration only while reset is held. It places each pair of edges well inside a reference period, so every overlap ends before the next reference edge, and each vector holds the same period and phase offset for four comparisons.

// File: rtl/epd_pkg.sv
package epd_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_UP   = 2'd1,
    ST_DN   = 2'd2,
    ST_OVL  = 2'd3
  } pfd_state_e;

  localparam int unsigned CAP_SHIFT_QUARTER = 2;
  localparam int unsigned CAP_SHIFT_EIGHTH  = 3;

endpackage

// File: rtl/epd_edge_sync.sv
module epd_edge_sync #(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic rise
);

  localparam int unsigned SH_W = SYNC_STAGES + 1;

  logic [SH_W-1:0] sh_q;
  logic [SH_W-1:0] sh_n;

  // stage 0 captures the raw input, the last stage is the edge-detect history
  always_comb begin
    sh_n = {sh_q[SH_W-2:0], din};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q <= '0;
    end else begin
      sh_q <= sh_n;
    end
  end

  assign rise = sh_q[SYNC_STAGES-1] & ~sh_q[SYNC_STAGES];

endmodule

// File: rtl/epd_period_meter.sv
module epd_period_meter
  import epd_pkg::*;
#(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ref_rise,
  input  logic             cap_sel,
  output logic [CNT_W-1:0] cap_lim,
  output logic             cap_vld
);

  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};
  localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

  logic [CNT_W-1:0] span_q, span_n;
  logic [CNT_W-1:0] meas_q, meas_n;
  logic             seen_q, seen_n;
  logic             vld_q,  vld_n;
  logic             meas_en;

  always_comb begin
    meas_en = ref_rise & seen_q;
    if (ref_rise) begin
      span_n = CNT_ONE;
    end else if (span_q == CNT_MAX) begin
      span_n = span_q;
    end else begin
      span_n = span_q + CNT_ONE;
    end
    meas_n = meas_en ? span_q : meas_q;
    seen_n = seen_q | ref_rise;
    vld_n  = vld_q | meas_en;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      span_q <= '0;
      meas_q <= '0;
      seen_q <= 1'b0;
      vld_q  <= 1'b0;
    end else begin
      span_q <= span_n;
      meas_q <= meas_n;
      seen_q <= seen_n;
      vld_q  <= vld_n;
    end
  end

  assign cap_lim = cap_sel ? (meas_q >> CAP_SHIFT_EIGHTH) : (meas_q >> CAP_SHIFT_QUARTER);
  assign cap_vld = vld_q;

endmodule

// File: rtl/epd_pulse_fsm.sv
module epd_pulse_fsm
  import epd_pkg::*;
#(
  parameter int unsigned CNT_W = 16,
  parameter int unsigned OVL_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ref_rise,
  input  logic             fb_rise,
  input  logic [OVL_W-1:0] ovl_len,
  input  logic             cap_en,
  input  logic [CNT_W-1:0] cap_lim,
  input  logic             cap_vld,
  output logic             pump_up,
  output logic             pump_dn,
  output logic             cap_hit
);

  localparam logic [CNT_W-1:0] W_ONE = CNT_W'(1);
  localparam logic [CNT_W-1:0] W_MAX = {CNT_W{1'b1}};
  localparam logic [OVL_W-1:0] O_ONE = OVL_W'(1);

  pfd_state_e       state_q, state_n;
  logic [CNT_W-1:0] upw_q, upw_n;
  logic [OVL_W-1:0] ovl_q, ovl_n;
  logic             capped_q, capped_n;
  logic [CNT_W-1:0] lim_eff;
  logic [OVL_W-1:0] ovl_load;
  logic             cap_act;

  always_comb begin
    lim_eff  = (cap_lim == '0) ? W_ONE : cap_lim;
    ovl_load = (ovl_len == '0) ? O_ONE : ovl_len;
    cap_act  = cap_en & cap_vld;
  end

  always_comb begin
    state_n  = state_q;
    upw_n    = upw_q;
    ovl_n    = ovl_q;
    capped_n = ref_rise ? 1'b0 : capped_q;
    unique case (state_q)
      ST_IDLE: begin
        if (ref_rise && fb_rise) begin
          state_n = ST_OVL;
          ovl_n   = ovl_load;
        end else if (ref_rise) begin
          state_n = ST_UP;
          upw_n   = W_ONE;
        end else if (fb_rise) begin
          state_n = ST_DN;
        end
      end
      ST_UP: begin
        if (fb_rise) begin
          state_n = ST_OVL;
          ovl_n   = ovl_load;
        end else if (ref_rise) begin
          upw_n = W_ONE;
        end else begin
          if (upw_q != W_MAX) begin
            upw_n = upw_q + W_ONE;
          end
          if (cap_act && !capped_q && (upw_q >= lim_eff)) begin
            capped_n = 1'b1;
          end
        end
      end
      ST_DN: begin
        if (ref_rise) begin
          state_n = ST_OVL;
          ovl_n   = ovl_load;
        end
      end
      ST_OVL: begin
        if (ovl_q <= O_ONE) begin
          state_n = ST_IDLE;
        end else begin
          ovl_n = ovl_q - O_ONE;
        end
      end
      default: state_n = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= ST_IDLE;
      upw_q    <= '0;
      ovl_q    <= '0;
      capped_q <= 1'b0;
    end else begin
      state_q  <= state_n;
      upw_q    <= upw_n;
      ovl_q    <= ovl_n;
      capped_q <= capped_n;
    end
  end

  assign pump_up = ((state_q == ST_UP) && !capped_q) || (state_q == ST_OVL);
  assign pump_dn = (state_q == ST_DN) || (state_q == ST_OVL);
  assign cap_hit = capped_q;

endmodule

// File: rtl/edge_phase_detector.sv
module edge_phase_detector #(
  parameter int unsigned CNT_W       = 16,
  parameter int unsigned OVL_W       = 4,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ref_in,
  input  logic             fb_in,
  input  logic [OVL_W-1:0] ovl_len,
  input  logic             cap_en,
  input  logic             cap_sel,
  output logic             pump_up,
  output logic             pump_dn,
  output logic             cap_hit
);

  localparam int unsigned N_CH = 2;

  logic [N_CH-1:0]  raw_in;
  logic [N_CH-1:0]  ch_rise;
  logic             ref_rise;
  logic             fb_rise;
  logic [CNT_W-1:0] cap_lim;
  logic             cap_vld;

  assign raw_in = {fb_in, ref_in};

  for (genvar g = 0; g < N_CH; g++) begin : g_sync
    epd_edge_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
      .clk  (clk),
      .rst_n(rst_n),
      .din  (raw_in[g]),
      .rise (ch_rise[g])
    );
  end

  assign ref_rise = ch_rise[0];
  assign fb_rise  = ch_rise[1];

  epd_period_meter #(.CNT_W(CNT_W)) u_meter (
    .clk     (clk),
    .rst_n   (rst_n),
    .ref_rise(ref_rise),
    .cap_sel (cap_sel),
    .cap_lim (cap_lim),
    .cap_vld (cap_vld)
  );

  epd_pulse_fsm #(.CNT_W(CNT_W), .OVL_W(OVL_W)) u_fsm (
    .clk     (clk),
    .rst_n   (rst_n),
    .ref_rise(ref_rise),
    .fb_rise (fb_rise),
    .ovl_len (ovl_len),
    .cap_en  (cap_en),
    .cap_lim (cap_lim),
    .cap_vld (cap_vld),
    .pump_up (pump_up),
    .pump_dn (pump_dn),
    .cap_hit (cap_hit)
  );

endmodule

// File: rtl/edge_phase_detector_chk.sv
module edge_phase_detector_chk #(
  parameter int unsigned OVL_W = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             ref_rise,
  input logic             fb_rise,
  input logic             pump_up,
  input logic             pump_dn,
  input logic             cap_hit,
  input logic             cap_en,
  input logic [OVL_W-1:0] ovl_len
);

  logic [OVL_W:0] both_run;
  logic           both_q;
  logic [OVL_W:0] ovl_exp;

  assign ovl_exp = (ovl_len == '0) ? (OVL_W+1)'(1) : {1'b0, ovl_len};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      both_run <= '0;
      both_q   <= 1'b0;
    end else begin
      both_q   <= pump_up & pump_dn;
      both_run <= (pump_up & pump_dn) ? both_run + 1'b1 : '0;
    end
  end

  AST_UP_TO_OVL: assert property (@(posedge clk) disable iff (!rst_n)
    (pump_up && !pump_dn && fb_rise) |=> (pump_up && pump_dn)); // R4

  AST_DN_TO_OVL: assert property (@(posedge clk) disable iff (!rst_n)
    (pump_dn && !pump_up && ref_rise) |=> (pump_up && pump_dn)); // R4

  AST_OVL_LEN: assert property (@(posedge clk) disable iff (!rst_n)
    (both_q && !(pump_up && pump_dn)) |-> (both_run == ovl_exp)); // R4

  AST_CAP_UP_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (cap_hit && !pump_dn) |-> !pump_up); // R6

  AST_CAP_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    ref_rise |=> !cap_hit); // R6

  AST_CAP_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cap_hit) |-> $past(cap_en)); // R8

endmodule

bind edge_phase_detector edge_phase_detector_chk #(.OVL_W(OVL_W)) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .ref_rise(ref_rise),
  .fb_rise (fb_rise),
  .pump_up (pump_up),
  .pump_dn (pump_dn),
  .cap_hit (cap_hit),
  .cap_en  (cap_en),
  .ovl_len (ovl_len)
);

// File: tb/edge_phase_detector_tb_top.sv
module edge_phase_detector_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int LEAD       = 40;
  localparam int EVENTS     = 4;
  localparam int NVEC       = 10;

  typedef struct packed {
    logic [15:0]        per;
    logic signed [15:0] dly;
    logic [3:0]         ovl;
    logic               en;
    logic               sel;
  } vec_t;

  // period, feedback delay (positive: reference leads), overlap, cap enable, cap select
  localparam vec_t VECS [NVEC] = '{
    '{16'd40,  16'sd5,  4'd2,  1'b0, 1'b0},  // R2 plain lead
    '{16'd40, -16'sd5,  4'd2,  1'b0, 1'b0},  // R3 plain lag
    '{16'd40,  16'sd0,  4'd3,  1'b0, 1'b0},  // R4 aligned edges
    '{16'd40,  16'sd15, 4'd1,  1'b1, 1'b0},  // R5 R6 R9 quarter cap
    '{16'd48,  16'sd12, 4'd2,  1'b1, 1'b1},  // R5 R6 eighth cap
    '{16'd40, -16'sd15, 4'd2,  1'b1, 1'b1},  // R7 down not limited
    '{16'd40,  16'sd15, 4'd0,  1'b0, 1'b1},  // R8 cap off, zero overlap
    '{16'd40,  16'sd8,  4'd4,  1'b1, 1'b0},  // R5 below limit
    '{16'd40,  16'sd10, 4'd2,  1'b1, 1'b0},  // R6 spacing equal to limit
    '{16'd40, -16'sd1,  4'd15, 1'b1, 1'b0}   // R4 longest overlap
  };

  logic       clk;
  logic       rst_n;
  logic       ref_in;
  logic       fb_in;
  logic [3:0] ovl_len;
  logic       cap_en;
  logic       cap_sel;
  logic       pump_up;
  logic       pump_dn;
  logic       cap_hit;

  int checks;
  int fails;
  int n_up, n_dn, n_both, n_cap;
  bit done;

  edge_phase_detector #(.CNT_W(16), .OVL_W(4), .SYNC_STAGES(2)) dut_i (
    .clk    (clk),
    .rst_n  (rst_n),
    .ref_in (ref_in),
    .fb_in  (fb_in),
    .ovl_len(ovl_len),
    .cap_en (cap_en),
    .cap_sel(cap_sel),
    .pump_up(pump_up),
    .pump_dn(pump_dn),
    .cap_hit(cap_hit)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", what, act, exp);
    end
  endtask

  task automatic do_reset(input logic [3:0] o, input logic e, input logic s);
    @(negedge clk);
    rst_n   = 1'b0;
    ref_in  = 1'b0;
    fb_in   = 1'b0;
    ovl_len = o;
    cap_en  = e;
    cap_sel = s;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
  endtask

  function automatic logic pulse_at(input int t, input int start, input int per);
    if (t < start) return 1'b0;
    return (((t - start) % per) < 2) && (((t - start) / per) < EVENTS);
  endfunction

  task automatic run_vec(input int per, input int d, input logic [3:0] o,
                         input logic e, input logic s);
    logic prev_cap;
    do_reset(o, e, s);
    n_up = 0; n_dn = 0; n_both = 0; n_cap = 0;
    prev_cap = 1'b0;
    for (int t = 0; t < LEAD + (EVENTS + 1) * per; t++) begin
      @(negedge clk);
      if (pump_up && !pump_dn) n_up++;
      if (pump_dn && !pump_up) n_dn++;
      if (pump_up && pump_dn)  n_both++;
      if (cap_hit && !prev_cap) n_cap++;
      prev_cap = cap_hit;
      ref_in = pulse_at(t, LEAD, per);
      fb_in  = pulse_at(t, LEAD + d, per);
    end
  endtask

  initial begin
    int lim, ovl_e, exp_up, exp_dn, exp_cap;
    checks = 0; fails = 0; done = 0;
    rst_n = 1'b0; ref_in = 1'b0; fb_in = 1'b0;
    ovl_len = 4'd2; cap_en = 1'b0; cap_sel = 1'b0;

    // reset state
    repeat (2) @(negedge clk);
    check("R1 pump_up in reset", int'(pump_up), 0);
    check("R1 pump_dn in reset", int'(pump_dn), 0);
    check("R1 cap_hit in reset", int'(cap_hit), 0);

    // vector table: four comparisons per vector, totals over the run
    for (int i = 0; i < NVEC; i++) begin
      int per, d;
      per = int'(VECS[i].per);
      d   = int'($signed(VECS[i].dly));
      run_vec(per, d, VECS[i].ovl, VECS[i].en, VECS[i].sel);
      lim   = VECS[i].sel ? (per >> 3) : (per >> 2);
      if (lim < 1) lim = 1;
      ovl_e = (VECS[i].ovl == 4'd0) ? 1 : int'(VECS[i].ovl);
      exp_cap = 0;
      exp_up  = 0;
      exp_dn  = 0;
      if (d > 0) begin
        if (VECS[i].en && d > lim) begin
          // first comparison has no measured period yet
          exp_up  = d + (EVENTS - 1) * lim;
          exp_cap = EVENTS - 1;
        end else begin
          exp_up = EVENTS * d;
        end
      end else if (d < 0) begin
        exp_dn = EVENTS * (-d);
      end
      check($sformatf("vec%0d up-only cycles R2 R5 R8 R9", i), n_up, exp_up);
      check($sformatf("vec%0d down-only cycles R3 R7", i), n_dn, exp_dn);
      check($sformatf("vec%0d overlap cycles R4", i), n_both, EVENTS * ovl_e);
      check($sformatf("vec%0d cap_hit rises R6", i), n_cap, exp_cap);
    end

    // cap flag held until the next reference edge, then cleared; edge latency
    run_vec(40, 15, 4'd1, 1'b1, 1'b0);
    check("R6 cap_hit held after capped pulse", int'(cap_hit), 1);
    @(negedge clk);
    ref_in = 1'b1;
    @(negedge clk);
    check("R10 no early response edge1", int'(pump_up), 0);
    @(negedge clk);
    ref_in = 1'b0;
    check("R10 no early response edge2", int'(pump_up), 0);
    check("R6 cap_hit still set before edge", int'(cap_hit), 1);
    @(negedge clk);
    check("R10 pump_up after third edge", int'(pump_up), 1);
    check("R6 cap_hit cleared by reference edge", int'(cap_hit), 0);

    // asynchronous reset in the middle of an up pulse
    @(negedge clk);
    check("R2 up pulse held while waiting", int'(pump_up), 1);
    rst_n = 1'b0;
    #1;
    check("R1 pump_up cleared by async reset", int'(pump_up), 0);
    check("R1 pump_dn cleared by async reset", int'(pump_dn), 0);

    // reset discards the period: first comparison afterwards is not cut
    run_vec(40, 15, 4'd1, 1'b1, 1'b0);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

endmodule